// File: doc/BRIEF.md
# Per-ASIC Crosstalk Coincidence Filter

This block sits behind the wire-hit readout and marks hits that look like front-end crosstalk. Each hit arrives with a board number, a front-end channel and a TDC count. The block groups hits by readout chip, where the chip is the channel divided by eight. If a chip holds a tight burst of four or more hits, the hits in that burst are marked as crosstalk.

An event is streamed in over a valid/ready interface. The event closes on an end-of-event strobe; a hit presented in the same cycle as the strobe belongs to that event. The block then works through each chip that has at least four hits. It sorts that chip's TDC values and looks for the widest tight group of sorted values. The block then returns one keep/drop flag for each accepted hit, in the order the hits arrived. Input stays closed until the last flag has been taken.

Top module: `xtalk_filter`

## Requirements
- R1: After reset, `hitReady` is 1 and `flagValid` is 0.
- R2: Hits are grouped by board and chip, where chip = channel / 8. Channels 0–7 form chip 0 and channels 8–15 form chip 1, and so on. Hits on different chips or on different boards never count toward the same group.
- R3: A hit whose board is 500 or more, or whose chip index is 6 or more (channel 48 and up), is always kept.
- R4: A chip with fewer than 4 hits in the event has all of its hits kept.
- R5: A chip's TDC values are taken in ascending order, with equal values kept in arrival order. A run of sorted values qualifies when last minus first is at most 16. A spread of 17 does not qualify.
- R6: The search starts at the chip's full hit count and goes down to 4. For each size it tries the earliest sorted run first. Only the first qualifying run is dropped; every other hit on that chip is kept.
- R7: When `cfgEnable` is 0 at end-of-event, every hit of that event is kept.
- R8: Only the first 8 hits of a chip, in arrival order, take part in its search. Any later hits on that chip are kept.
- R9: An event holds at most 16 hits. `hitReady` is 0 while 16 hits are held.
- R10: There is exactly one flag per accepted hit, in arrival order. `flagDrop` is 1 for drop and 0 for keep. While `flagValid` is high and `flagReady` is low, `flagValid` and `flagDrop` hold their values. `flagLast` marks the final flag. `hitReady` stays 0 from end-of-event until the final flag is taken.
- R11: An end-of-event with no hits produces no flags, and the block stays ready for hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Filter enable, sampled at end-of-event |
| hitValid | input | 1 | Hit present |
| hitReady | output | 1 | Block accepts a hit |
| hitBoard | input | 9 | Board number of the hit |
| hitChan | input | 6 | Front-end channel of the hit |
| hitTdc | input | 11 | TDC count of the hit |
| eventEnd | input | 1 | Closes the event (honoured while collecting) |
| flagValid | output | 1 | A flag is presented |
| flagReady | input | 1 | Consumer takes the flag |
| flagDrop | output | 1 | 1 = drop as crosstalk, 0 = keep |
| flagLast | output | 1 | Flag of the event's final hit |

## Verification
The bench targets the window edge, where a spread of 16 must drop the run and a spread of 17 must not. A comparison off by one would either miss real bursts or drop real hits. It also places hits on channels 7 and 8 of the same board and on the same channel of two boards. An address split that merged chips would then drop isolated hits. A burst that appears only after a chip's eighth hit must survive, which catches a design that lets its group buffer grow past its depth. Cases with several candidate runs check that the widest and earliest run wins. Checking smallest-first or latest-first would drop the wrong hits. Stalled drains check that flags hold under back-pressure and keep arrival order.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    ST_COLLECT, ST_PICK, ST_GATHER, ST_SORT, ST_SEARCH, ST_OUT
  } ctlState_t;

  typedef struct packed {
    logic             clear;
    logic             push;
    logic             markSkip;
    logic             startGrp;
    logic             takeHit;
    logic             sortStep;
    logic             sortOdd;
    logic             flagWin;
    logic [IDX_W-1:0] pIdx;
    logic [IDX_W-1:0] jIdx;
    logic [IDX_W-1:0] kIdx;
    logic [IDX_W-1:0] nCnt;
    logic [IDX_W-1:0] outIdx;
  } ctlStrobe_t;

  typedef struct packed {
    logic [IDX_W-1:0] hitCnt;
    logic [IDX_W-1:0] grpCnt;
    logic             pDone;
    logic             pValid;
    logic             jMatch;
    logic             jDone;
    logic             winOk;
    logic             dropAt;
  } dpStatus_t;
endpackage

// File: rtl/xtalk_dp.sv
module xtalk_dp
  import xtalk_pkg::*;
#(
  parameter int MAX_HITS        = 16,
  parameter int ASIC_DEPTH      = 8,
  parameter int MIN_HITS        = 4,
  parameter int WINDOW          = 16,
  parameter int BOARD_W         = 9,
  parameter int CHAN_W          = 6,
  parameter int TDC_W           = 11,
  parameter int NUM_BOARDS      = 500,
  parameter int ASICS_PER_BOARD = 6,
  parameter int CHANS_PER_ASIC  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [BOARD_W-1:0] hitBoard,
  input  logic [CHAN_W-1:0]  hitChan,
  input  logic [TDC_W-1:0]   hitTdc,
  output dpStatus_t          st
);
  localparam int HIT_AW  = $clog2(MAX_HITS);
  localparam int SLOT_AW = $clog2(ASIC_DEPTH);
  localparam int ASIC_SH = $clog2(CHANS_PER_ASIC);

  logic [BOARD_W-1:0] brdQ  [MAX_HITS];
  logic [CHAN_W-1:0]  asicQ [MAX_HITS];
  logic [TDC_W-1:0]   tdcQ  [MAX_HITS];
  logic [MAX_HITS-1:0] doneQ, dropQ, validQ;
  logic [IDX_W-1:0]   hitCnt, grpCnt;
  logic [HIT_AW-1:0]  leader;
  logic [TDC_W-1:0]   grpTdc [ASIC_DEPTH];
  logic [HIT_AW-1:0]  grpIdx [ASIC_DEPTH];

  logic [HIT_AW-1:0]  pI, jI, oI, wrI;
  logic [SLOT_AW-1:0] kI, lastI, slotI;
  logic [IDX_W-1:0]   lastSum;
  logic [CHAN_W-1:0]  asicIn;

  assign pI      = ctl.pIdx[HIT_AW-1:0];
  assign jI      = ctl.jIdx[HIT_AW-1:0];
  assign oI      = ctl.outIdx[HIT_AW-1:0];
  assign wrI     = hitCnt[HIT_AW-1:0];
  assign kI      = ctl.kIdx[SLOT_AW-1:0];
  assign lastSum = ctl.kIdx + ctl.nCnt - 8'd1;
  assign lastI   = lastSum[SLOT_AW-1:0];
  assign slotI   = grpCnt[SLOT_AW-1:0];
  assign asicIn  = hitChan >> ASIC_SH;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      hitCnt <= '0;
      grpCnt <= '0;
      leader <= '0;
      doneQ  <= '0;
      dropQ  <= '0;
      validQ <= '0;
    end else begin
      if (ctl.push) begin
        brdQ[wrI]   <= hitBoard;
        asicQ[wrI]  <= asicIn;
        tdcQ[wrI]   <= hitTdc;
        validQ[wrI] <= (int'(hitBoard) < NUM_BOARDS) && (int'(asicIn) < ASICS_PER_BOARD);
        hitCnt      <= hitCnt + 8'd1;
      end
      if (ctl.markSkip) doneQ[pI] <= 1'b1;
      if (ctl.startGrp) begin
        leader <= pI;
        grpCnt <= '0;
      end
      if (ctl.takeHit) begin
        doneQ[jI] <= 1'b1;
        if (int'(grpCnt) < ASIC_DEPTH) begin
          grpTdc[slotI] <= tdcQ[jI];
          grpIdx[slotI] <= jI;
          grpCnt        <= grpCnt + 8'd1;
        end
      end
      if (ctl.sortStep) begin
        for (int i = 0; i < ASIC_DEPTH - 1; i++) begin
          if ((i % 2) == int'(ctl.sortOdd) && (i + 1) < int'(grpCnt) &&
              grpTdc[i] > grpTdc[i+1]) begin
            grpTdc[i]   <= grpTdc[i+1];
            grpTdc[i+1] <= grpTdc[i];
            grpIdx[i]   <= grpIdx[i+1];
            grpIdx[i+1] <= grpIdx[i];
          end
        end
      end
      if (ctl.flagWin) begin
        for (int s = 0; s < ASIC_DEPTH; s++) begin
          if (s >= int'(ctl.kIdx) && s < int'(ctl.kIdx) + int'(ctl.nCnt))
            dropQ[grpIdx[s]] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    st.hitCnt = hitCnt;
    st.grpCnt = grpCnt;
    st.pDone  = doneQ[pI];
    st.pValid = validQ[pI];
    st.jDone  = doneQ[jI];
    st.jMatch = (brdQ[jI] == brdQ[leader]) && (asicQ[jI] == asicQ[leader]);
    st.winOk  = (grpTdc[lastI] - grpTdc[kI]) <= TDC_W'(WINDOW);
    st.dropAt = dropQ[oI];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> int'(hitCnt) < MAX_HITS); // R9
  AST_GROUP_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    int'(grpCnt) <= ASIC_DEPTH); // R8
  AST_GROUP_MIN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagWin |-> int'(grpCnt) >= MIN_HITS); // R4

  for (genvar g = 0; g < ASIC_DEPTH - 1; g++) begin : gSortChk
    AST_SORTED: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.flagWin && (g + 1) < int'(grpCnt)) |-> grpTdc[g] <= grpTdc[g+1]); // R5
  end
endmodule

// File: rtl/xtalk_ctrl.sv
module xtalk_ctrl
  import xtalk_pkg::*;
#(
  parameter int MAX_HITS   = 16,
  parameter int ASIC_DEPTH = 8,
  parameter int MIN_HITS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic       hitValid,
  output logic       hitReady,
  input  logic       eventEnd,
  output logic       flagValid,
  input  logic       flagReady,
  output logic       flagDrop,
  output logic       flagLast,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl
);
  localparam int PASS_W = $clog2(ASIC_DEPTH);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(ASIC_DEPTH - 1);
  localparam logic [IDX_W-1:0]  MAX_CNT   = IDX_W'(MAX_HITS);
  localparam logic [IDX_W-1:0]  MIN_CNT   = IDX_W'(MIN_HITS);

  ctlState_t         state;
  logic [IDX_W-1:0]  p, j, k, n, outPtr;
  logic [PASS_W-1:0] passCnt;
  logic              enLatched;
  logic              winFits;

  assign winFits = (k + n) <= st.grpCnt;

  always_comb begin
    ctl        = '0;
    ctl.pIdx   = p;
    ctl.jIdx   = j;
    ctl.kIdx   = k;
    ctl.nCnt   = n;
    ctl.outIdx = outPtr;
    hitReady   = (state == ST_COLLECT) && (st.hitCnt < MAX_CNT);
    ctl.push   = hitValid && hitReady;
    flagValid  = (state == ST_OUT);
    flagDrop   = st.dropAt;
    flagLast   = flagValid && (outPtr == st.hitCnt - 8'd1);
    case (state)
      ST_PICK:   if (p != st.hitCnt && !st.pDone) begin
                   ctl.markSkip = !st.pValid;
                   ctl.startGrp = st.pValid;
                 end
      ST_GATHER: ctl.takeHit = (j != st.hitCnt) && st.jMatch && !st.jDone;
      ST_SORT:   begin
                   ctl.sortStep = 1'b1;
                   ctl.sortOdd  = passCnt[0];
                 end
      ST_SEARCH: ctl.flagWin = winFits && st.winOk;
      ST_OUT:    ctl.clear = flagReady && flagLast;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_COLLECT;
      p         <= '0;
      j         <= '0;
      k         <= '0;
      n         <= '0;
      outPtr    <= '0;
      passCnt   <= '0;
      enLatched <= 1'b1;
    end else begin
      case (state)
        ST_COLLECT: if (eventEnd && (st.hitCnt != '0 || ctl.push)) begin
          enLatched <= cfgEnable;
          outPtr    <= '0;
          p         <= '0;
          state     <= cfgEnable ? ST_PICK : ST_OUT;
        end
        ST_PICK: begin
          if (p == st.hitCnt) begin
            outPtr <= '0;
            state  <= ST_OUT;
          end else if (st.pDone || !st.pValid) begin
            p <= p + 8'd1;
          end else begin
            j     <= p;
            state <= ST_GATHER;
          end
        end
        ST_GATHER: begin
          if (j == st.hitCnt) begin
            passCnt <= '0;
            state   <= (st.grpCnt >= MIN_CNT) ? ST_SORT : ST_PICK;
          end else begin
            j <= j + 8'd1;
          end
        end
        ST_SORT: begin
          passCnt <= passCnt + 1'b1;
          if (passCnt == LAST_PASS) begin
            n     <= st.grpCnt;
            k     <= '0;
            state <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (!winFits) begin
            if (n <= MIN_CNT) state <= ST_PICK;
            else begin
              n <= n - 8'd1;
              k <= '0;
            end
          end else if (st.winOk) begin
            state <= ST_PICK;
          end else begin
            k <= k + 8'd1;
          end
        end
        ST_OUT: if (flagReady) begin
          if (flagLast) state <= ST_COLLECT;
          else outPtr <= outPtr + 8'd1;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flagValid && !flagReady) |=> (flagValid && $stable(flagDrop) && $stable(flagLast))); // R10
  AST_OFF_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (flagValid && !enLatched) |-> !flagDrop); // R7
  AST_SEARCH_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEARCH) |-> (n >= MIN_CNT && n <= IDX_W'(ASIC_DEPTH))); // R6
endmodule

// File: rtl/xtalk_filter.sv
module xtalk_filter
  import xtalk_pkg::*;
#(
  parameter int MAX_HITS        = 16,
  parameter int ASIC_DEPTH      = 8,
  parameter int MIN_HITS        = 4,
  parameter int WINDOW          = 16,
  parameter int BOARD_W         = 9,
  parameter int CHAN_W          = 6,
  parameter int TDC_W           = 11,
  parameter int NUM_BOARDS      = 500,
  parameter int ASICS_PER_BOARD = 6,
  parameter int CHANS_PER_ASIC  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               hitValid,
  output logic               hitReady,
  input  logic [BOARD_W-1:0] hitBoard,
  input  logic [CHAN_W-1:0]  hitChan,
  input  logic [TDC_W-1:0]   hitTdc,
  input  logic               eventEnd,
  output logic               flagValid,
  input  logic               flagReady,
  output logic               flagDrop,
  output logic               flagLast
);
  ctlStrobe_t ctl;
  dpStatus_t  st;

  xtalk_ctrl #(
    .MAX_HITS(MAX_HITS), .ASIC_DEPTH(ASIC_DEPTH), .MIN_HITS(MIN_HITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .hitValid(hitValid),
    .hitReady(hitReady), .eventEnd(eventEnd), .flagValid(flagValid),
    .flagReady(flagReady), .flagDrop(flagDrop), .flagLast(flagLast),
    .st(st), .ctl(ctl)
  );

  xtalk_dp #(
    .MAX_HITS(MAX_HITS), .ASIC_DEPTH(ASIC_DEPTH), .MIN_HITS(MIN_HITS),
    .WINDOW(WINDOW), .BOARD_W(BOARD_W), .CHAN_W(CHAN_W), .TDC_W(TDC_W),
    .NUM_BOARDS(NUM_BOARDS), .ASICS_PER_BOARD(ASICS_PER_BOARD),
    .CHANS_PER_ASIC(CHANS_PER_ASIC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hitBoard(hitBoard),
    .hitChan(hitChan), .hitTdc(hitTdc), .st(st)
  );
endmodule

// File: tb/xtalk_filter_tb.sv
module xtalk_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b1;
  logic        hitValid = 1'b0;
  logic        hitReady;
  logic [8:0]  hitBoard = '0;
  logic [5:0]  hitChan = '0;
  logic [10:0] hitTdc = '0;
  logic        eventEnd = 1'b0;
  logic        flagValid;
  logic        flagReady = 1'b0;
  logic        flagDrop;
  logic        flagLast;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  int evB[$], evC[$], evT[$];
  bit expDrop[$];

  always #10 clk = ~clk;

  xtalk_filter u_dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .hitValid(hitValid),
    .hitReady(hitReady), .hitBoard(hitBoard), .hitChan(hitChan),
    .hitTdc(hitTdc), .eventEnd(eventEnd), .flagValid(flagValid),
    .flagReady(flagReady), .flagDrop(flagDrop), .flagLast(flagLast)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsFailed++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic addHit(int b, int c, int t);
    evB.push_back(b); evC.push_back(c); evT.push_back(t);
  endtask

  task automatic computeExp(bit en);
    bit done[$];
    int n = evB.size();
    expDrop = {};
    for (int i = 0; i < n; i++) begin expDrop.push_back(1'b0); done.push_back(1'b0); end
    if (!en) return;
    for (int i = 0; i < n; i++) begin
      int mem[$];
      bit found;
      if (done[i]) continue;
      if (evB[i] >= 500 || evC[i] / 8 >= 6) begin done[i] = 1'b1; continue; end
      for (int j = i; j < n; j++)
        if (!done[j] && evB[j] == evB[i] && evC[j] / 8 == evC[i] / 8) begin
          done[j] = 1'b1;
          if (mem.size() < 8) mem.push_back(j);
        end
      if (mem.size() < 4) continue;
      for (int a = 0; a < mem.size(); a++)
        for (int b = 0; b + 1 < mem.size() - a; b++)
          if (evT[mem[b]] > evT[mem[b+1]] ||
              (evT[mem[b]] == evT[mem[b+1]] && mem[b] > mem[b+1])) begin
            int tmp = mem[b]; mem[b] = mem[b+1]; mem[b+1] = tmp;
          end
      found = 1'b0;
      for (int sz = mem.size(); sz >= 4 && !found; sz--)
        for (int k = 0; k + sz <= mem.size() && !found; k++)
          if (evT[mem[k+sz-1]] - evT[mem[k]] <= 16) begin
            found = 1'b1;
            for (int s = k; s < k + sz; s++) expDrop[mem[s]] = 1'b1;
          end
    end
  endtask

  task automatic sendHit(int b, int c, int t);
    @(negedge clk);
    while (!hitReady) @(negedge clk);
    hitValid = 1'b1; hitBoard = 9'(b); hitChan = 6'(c); hitTdc = 11'(t);
    @(negedge clk);
    hitValid = 1'b0;
  endtask

  task automatic runEvent(string tag, bit en, bit fullCheck);
    int n = evB.size();
    int idx = 0;
    int cyc = 0;
    bit held = 1'b0;
    bit prevDrop = 1'b0;
    bit readyBad = 1'b0;
    cfgEnable = en;
    for (int i = 0; i < n; i++) sendHit(evB[i], evC[i], evT[i]);
    if (fullCheck) check("R9", int'(hitReady), 0, "hitReady with full event");
    @(negedge clk); eventEnd = 1'b1;
    @(negedge clk); eventEnd = 1'b0;
    computeExp(en);
    while (idx < n) begin
      bit rdy;
      @(negedge clk);
      cyc++;
      if (hitReady) readyBad = 1'b1;
      rdy = (cyc % 3) != 1;
      if (flagValid) begin
        if (held) check("R10", int'(flagDrop), int'(prevDrop), "flag held under stall");
        if (rdy) begin
          check(tag, int'(flagDrop), int'(expDrop[idx]), $sformatf("drop of hit %0d", idx));
          check("R10", int'(flagLast), int'(idx == n - 1), $sformatf("last of hit %0d", idx));
          idx++;
        end
      end
      held = flagValid && !rdy;
      prevDrop = flagDrop;
      flagReady = rdy;
    end
    @(negedge clk);
    flagReady = 1'b0;
    check("R10", int'(readyBad), 0, "hitReady during flag drain");
    check("R10", int'(flagValid), 0, "flagValid after last");
    check("R10", int'(hitReady), 1, "hitReady after drain");
    evB = {}; evC = {}; evT = {};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(hitReady), 1, "hitReady after reset");
    check("R1", int'(flagValid), 0, "flagValid after reset");

    // R6: four hits within 14 counts dropped, outlier and other chip kept
    addHit(3, 8, 100); addHit(3, 16, 101); addHit(3, 9, 105);
    addHit(3, 10, 110); addHit(3, 11, 114); addHit(3, 12, 300);
    runEvent("R6", 1'b1, 1'b0);

    // R2: chip boundary at channel 7/8 and same channel on two boards
    addHit(5, 0, 50); addHit(5, 3, 50); addHit(5, 7, 50); addHit(5, 8, 50);
    addHit(6, 0, 50); addHit(7, 9, 50); addHit(7, 15, 50); addHit(6, 16, 50);
    runEvent("R2", 1'b1, 1'b0);

    // R5: spread 16 drops, spread 17 keeps
    addHit(9, 20, 200); addHit(9, 21, 216); addHit(9, 22, 205); addHit(9, 23, 210);
    addHit(9, 24, 0);   addHit(9, 25, 17);  addHit(9, 26, 5);   addHit(9, 27, 10);
    runEvent("R5", 1'b1, 1'b0);

    // R4: three coincident hits are kept
    addHit(11, 4, 70); addHit(11, 5, 70); addHit(11, 6, 70);
    runEvent("R4", 1'b1, 1'b0);

    // R3: out-of-range board and out-of-range chip are kept
    for (int i = 0; i < 4; i++) addHit(500, i, 30);
    for (int i = 0; i < 4; i++) addHit(2, 50 + i, 30);
    runEvent("R3", 1'b1, 1'b0);

    // R6: widest first fails, earliest four-hit run wins
    addHit(4, 32, 40); addHit(4, 33, 10); addHit(4, 34, 24);
    addHit(4, 35, 41); addHit(4, 36, 12); addHit(4, 37, 20);
    runEvent("R6", 1'b1, 1'b0);

    // R5: equal TDC values, tie order by arrival
    addHit(8, 1, 90); addHit(8, 2, 90); addHit(8, 3, 90);
    addHit(8, 4, 90); addHit(8, 5, 107); addHit(8, 6, 90);
    runEvent("R5", 1'b1, 1'b0);

    // R8: burst after the eighth hit of a chip is kept
    for (int i = 0; i < 8; i++) addHit(12, 40, i * 200);
    for (int i = 0; i < 4; i++) addHit(12, 41, 500);
    runEvent("R8", 1'b1, 1'b0);

    // R7: filter disabled keeps a clear burst
    addHit(3, 8, 100); addHit(3, 9, 101); addHit(3, 10, 102); addHit(3, 11, 103);
    runEvent("R7", 1'b0, 1'b0);

    // R11: empty event yields no flags
    @(negedge clk); eventEnd = 1'b1;
    @(negedge clk); eventEnd = 1'b0;
    repeat (5) @(negedge clk);
    check("R11", int'(flagValid), 0, "flagValid after empty event");
    check("R11", int'(hitReady), 1, "hitReady after empty event");

    // R9: full event of sixteen hits
    for (int i = 0; i < 16; i++) addHit(1 + (i % 2), i % 12, 100 + $urandom_range(0, 25));
    runEvent("R9", 1'b1, 1'b1);

    // R6: assorted dense events
    for (int e = 0; e < 20; e++) begin
      int nh = $urandom_range(1, 16);
      for (int i = 0; i < nh; i++)
        addHit($urandom_range(1, 2), $urandom_range(0, 15), 300 + $urandom_range(0, 40));
      runEvent("R6", 1'b1, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule